// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits between two independent memory ports, called left and right, that share one storage array. Each port presents an enable, a write strobe and an address on every clock. When both ports are enabled on the same address in the same cycle, the arbiter grants the location to one of them. It drives an active-low busy flag to the other port and withholds that port's write permission.

The port that was already parked on the address keeps it, and the newcomer is refused. A port counts as parked when it was enabled at that same address in the previous cycle. When both ports arrive in the same cycle, the left port wins. Once a port has won, a registered holder keeps the grant with that port for as long as the collision lasts. The grant is released in the same cycle that the addresses differ or either enable drops.

Several arbiters can run side by side for a wider word. One of them is strapped as master and computes the busy flags. The others are strapped as slaves: they pass in the master's flags and apply them to their own write gating, so all slices refuse the same port.

Top module: `port_clash_arbiter`

## Requirements
- R1: While `rst_n` is low, both busy flags are high and both write permissions are low, whatever the port inputs are.
- R2: In master mode (`master_sel`=1), both busy flags stay high when at most one port is enabled or the two addresses differ.
- R3: In master mode, if left was enabled at address X in the previous cycle and right becomes enabled at X now, `rgt_busy_n` is low and `lft_busy_n` is high in this same cycle.
- R4: In master mode, if right was enabled at address X in the previous cycle and left becomes enabled at X now, `lft_busy_n` is low and `rgt_busy_n` is high.
- R5: In master mode, when neither colliding port was parked on the shared address in the previous cycle (this includes both arriving together), the left port wins and `rgt_busy_n` is low.
- R6: In master mode, a port that has won keeps its grant in every following cycle of an unbroken collision, whatever the write strobes do.
- R7: In master mode, the busy flag is released (high) in the first cycle in which the addresses differ or either enable is low.
- R8: A port's write permission `*_wr_ok` is high exactly when that port's enable and write strobe are high and its busy flag output is high, in both modes.
- R9: A collision where both ports only read (write strobes low) still drives the loser's busy flag low.
- R10: In slave mode (`master_sel`=0), `lft_busy_n` and `rgt_busy_n` equal `lft_busy_in_n` and `rgt_busy_in_n`, and the local address comparison has no effect on them.
- R11: In master mode, the two busy flags are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_sel | input | 1 | 1: compute busy locally; 0: take busy from the inputs |
| lft_en | input | 1 | Left port enable |
| lft_wr | input | 1 | Left port write strobe |
| lft_addr | input | 13 | Left port address |
| lft_busy_in_n | input | 1 | Imported left busy flag, used in slave mode |
| rgt_en | input | 1 | Right port enable |
| rgt_wr | input | 1 | Right port write strobe |
| rgt_addr | input | 13 | Right port address |
| rgt_busy_in_n | input | 1 | Imported right busy flag, used in slave mode |
| lft_busy_n | output | 1 | Left busy flag, active low |
| rgt_busy_n | output | 1 | Right busy flag, active low |
| lft_wr_ok | output | 1 | Left write permitted this cycle |
| rgt_wr_ok | output | 1 | Right write permitted this cycle |

## Verification
The hardest case to reach is a collision whose arrival order is decided by history and not by the current inputs. One example is a right port that has been parked on an address, then a left port that moves onto it, and then a change of write strobes while the collision continues. The vector table is walked in order so that each row builds on the port history left by the rows before it, which reaches these late-arrival and grant-holding cases. Reset is also released while a collision is already on the ports, which checks that the empty history after reset falls back to the left-first tie-break.

// File: rtl/pca_pkg.sv
// Shared types for the port clash arbiter.
// Assumes: two ports only; holder encodes which of them owns a collision.
package pca_pkg;
    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;
endpackage

// File: rtl/pca_port_history.sv
// Remembers one port's enable and address from the previous cycle and
// reports whether the port was already parked on its current address.
// Assumes: a synchronous active-low reset clears the history.
module pca_port_history #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              was_here
);
    logic              prev_en;
    logic [ADDR_W-1:0] prev_addr;

    // Capture this cycle's request for comparison in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_en   <= en;
            prev_addr <= addr;
        end
    end

    // Parked means enabled now and last cycle on the same address.
    always_comb begin
        was_here = en && prev_en && (prev_addr == addr);
    end
endmodule

// File: rtl/pca_judge.sv
// Detects a collision between the two ports and picks the winner:
// current holder first, then the port parked earlier, then left on a tie.
// Assumes: holder is HOLD_NONE whenever the previous cycle had no collision.
module pca_judge
    import pca_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_was_here,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_was_here,
    input  holder_e           holder,
    output logic              collide,
    output holder_e           winner
);
    // Collision exists only with both enables on one address.
    always_comb begin
        collide = l_en && r_en && (l_addr == r_addr);
    end

    // Winner selection in priority order.
    always_comb begin
        if (!collide)
            winner = HOLD_NONE;
        else if (holder != HOLD_NONE)
            winner = holder;
        else if (r_was_here && !l_was_here)
            winner = HOLD_RIGHT;
        else
            winner = HOLD_LEFT;
    end
endmodule

// File: rtl/pca_holder.sv
// Registers the winner of an ongoing collision so the grant stays put.
// Assumes: cleared in slave mode, since the grant then comes from outside.
module pca_holder
    import pca_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    master_sel,
    input  logic    collide,
    input  holder_e winner,
    output holder_e holder
);
    // Keep the winner while the collision lasts, else forget it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            holder <= HOLD_NONE;
        else if (master_sel && collide)
            holder <= winner;
        else
            holder <= HOLD_NONE;
    end
endmodule

// File: rtl/pca_port_gate.sv
// Selects one port's busy flag (local or imported) and gates its write.
// Assumes: all inputs are settled within the cycle; output is combinational.
module pca_port_gate (
    input  logic rst_n,
    input  logic master_sel,
    input  logic local_lose,
    input  logic busy_in_n,
    input  logic en,
    input  logic wr,
    output logic busy_n,
    output logic wr_ok
);
    // Busy source by mode; forced inactive in reset.
    always_comb begin
        if (!rst_n)
            busy_n = 1'b1;
        else if (master_sel)
            busy_n = !local_lose;
        else
            busy_n = busy_in_n;
    end

    // A write goes through only for an enabled, non-busy port.
    always_comb begin
        wr_ok = rst_n && en && wr && busy_n;
    end
endmodule

// File: rtl/port_clash_arbiter.sv
// Top of the two-port address contention arbiter.
// Assumes: one clock, synchronous active-low reset, both ports synchronous.
module port_clash_arbiter
    import pca_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              lft_en,
    input  logic              lft_wr,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_busy_in_n,
    input  logic              rgt_en,
    input  logic              rgt_wr,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_busy_in_n,
    output logic              lft_busy_n,
    output logic              rgt_busy_n,
    output logic              lft_wr_ok,
    output logic              rgt_wr_ok
);
    logic    l_was_here;
    logic    r_was_here;
    logic    collide;
    holder_e winner;
    holder_e holder;
    logic    l_lose;
    logic    r_lose;

    pca_port_history #(.ADDR_W(ADDR_W)) hist_l_i (
        .clk(clk), .rst_n(rst_n), .en(lft_en), .addr(lft_addr),
        .was_here(l_was_here)
    );

    pca_port_history #(.ADDR_W(ADDR_W)) hist_r_i (
        .clk(clk), .rst_n(rst_n), .en(rgt_en), .addr(rgt_addr),
        .was_here(r_was_here)
    );

    pca_judge #(.ADDR_W(ADDR_W)) judge_i (
        .l_en(lft_en), .l_addr(lft_addr), .l_was_here(l_was_here),
        .r_en(rgt_en), .r_addr(rgt_addr), .r_was_here(r_was_here),
        .holder(holder), .collide(collide), .winner(winner)
    );

    pca_holder holder_i (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .collide(collide), .winner(winner), .holder(holder)
    );

    // The loser of a collision is the port that is not the winner.
    always_comb begin
        l_lose = collide && (winner == HOLD_RIGHT);
        r_lose = collide && (winner == HOLD_LEFT);
    end

    pca_port_gate gate_l_i (
        .rst_n(rst_n), .master_sel(master_sel), .local_lose(l_lose),
        .busy_in_n(lft_busy_in_n), .en(lft_en), .wr(lft_wr),
        .busy_n(lft_busy_n), .wr_ok(lft_wr_ok)
    );

    pca_port_gate gate_r_i (
        .rst_n(rst_n), .master_sel(master_sel), .local_lose(r_lose),
        .busy_in_n(rgt_busy_in_n), .en(rgt_en), .wr(rgt_wr),
        .busy_n(rgt_busy_n), .wr_ok(rgt_wr_ok)
    );
endmodule

// File: rtl/pca_checker.sv
// Property checks on the arbiter's ports, bound into every instance.
module pca_checker #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_sel,
    input logic              lft_en,
    input logic              lft_wr,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              lft_busy_in_n,
    input logic              rgt_en,
    input logic              rgt_wr,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              rgt_busy_in_n,
    input logic              lft_busy_n,
    input logic              rgt_busy_n,
    input logic              lft_wr_ok,
    input logic              rgt_wr_ok
);
    logic same_loc;
    assign same_loc = lft_en && rgt_en && (lft_addr == rgt_addr);

    AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
        master_sel |-> (lft_busy_n || rgt_busy_n)); // R11

    AST_QUIET_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !same_loc) |-> (lft_busy_n && rgt_busy_n)); // R2

    AST_CLASH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && same_loc) |-> (lft_busy_n != rgt_busy_n)); // R9

    AST_GATE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        !lft_busy_n |-> !lft_wr_ok); // R8

    AST_GATE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !rgt_busy_n |-> !rgt_wr_ok); // R8

    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && same_loc && $past(master_sel) && $past(same_loc)
         && $past(rst_n)) |-> (lft_busy_n == $past(lft_busy_n))); // R6

    AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (lft_busy_n == lft_busy_in_n
                         && rgt_busy_n == rgt_busy_in_n)); // R10
endmodule

bind port_clash_arbiter pca_checker #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/port_clash_arbiter_tb_top.sv
module port_clash_arbiter_tb_top;
    localparam int AW = 13;
    localparam logic [AW-1:0] A = 13'h0123;
    localparam logic [AW-1:0] B = 13'h1FFF;
    localparam logic [AW-1:0] C = 13'h0AAA;

    typedef struct packed {
        logic          m;
        logic          le;
        logic          lw;
        logic [AW-1:0] la;
        logic          re;
        logic          rw;
        logic [AW-1:0] ra;
        logic          lbi;
        logic          rbi;
        logic          xlb;
        logic          xrb;
        logic          xlok;
        logic          xrok;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 19;
    // Rows run in order; each builds on the port history of the row before.
    localparam vec_t VECS [NV] = '{
        '{1,0,0,A, 0,0,A, 1,1, 1,1,0,0, 2},  // R2 idle
        '{1,1,0,A, 0,0,A, 1,1, 1,1,0,0, 2},  // R2 one port only
        '{1,1,0,A, 1,1,A, 1,1, 1,0,0,0, 3},  // R3 right arrives late
        '{1,1,0,A, 1,1,A, 1,1, 1,0,0,0, 6},  // R6 grant kept
        '{1,1,1,A, 1,1,A, 1,1, 1,0,1,0, 8},  // R8 winner writes
        '{1,1,1,A, 1,1,B, 1,1, 1,1,1,1, 7},  // R7 addresses split
        '{1,1,1,B, 1,0,B, 1,1, 0,1,0,0, 4},  // R4 left arrives late
        '{1,1,1,B, 1,1,B, 1,1, 0,1,0,1, 6},  // R6 strobes change
        '{1,1,1,B, 0,0,B, 1,1, 1,1,1,0, 7},  // R7 enable drops
        '{1,0,0,B, 0,0,B, 1,1, 1,1,0,0, 2},  // R2 idle
        '{1,1,0,A, 1,0,A, 1,1, 1,0,0,0, 9},  // R9 R5 read clash together
        '{1,1,1,A, 1,1,A, 1,1, 1,0,1,0, 6},  // R6 held by left
        '{1,1,0,A, 1,0,B, 1,1, 1,1,0,0, 2},  // R2 apart
        '{1,1,1,C, 1,1,C, 1,1, 1,0,1,0, 5},  // R5 both move together
        '{0,1,1,A, 1,1,A, 0,1, 0,1,0,1, 10}, // R10 slave imports left busy
        '{0,1,1,A, 1,1,A, 1,1, 1,1,1,1, 10}, // R10 local clash ignored
        '{0,1,1,A, 1,1,B, 1,0, 1,0,1,0, 10}, // R10 imported right busy
        '{1,1,1,A, 1,1,A, 1,1, 1,0,1,0, 3},  // R3 back to master
        '{1,0,0,A, 0,0,A, 1,1, 1,1,0,0, 2}   // R2 idle
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_sel = 1'b1;
    logic          lft_en = 1'b0, lft_wr = 1'b0, lft_busy_in_n = 1'b1;
    logic          rgt_en = 1'b0, rgt_wr = 1'b0, rgt_busy_in_n = 1'b1;
    logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
    logic          lft_busy_n, rgt_busy_n, lft_wr_ok, rgt_wr_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    port_clash_arbiter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .lft_en(lft_en), .lft_wr(lft_wr), .lft_addr(lft_addr),
        .lft_busy_in_n(lft_busy_in_n),
        .rgt_en(rgt_en), .rgt_wr(rgt_wr), .rgt_addr(rgt_addr),
        .rgt_busy_in_n(rgt_busy_in_n),
        .lft_busy_n(lft_busy_n), .rgt_busy_n(rgt_busy_n),
        .lft_wr_ok(lft_wr_ok), .rgt_wr_ok(rgt_wr_ok)
    );

    task automatic check(input string what, input int req,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic xlb, input logic xrb,
                             input logic xlok, input logic xrok);
        check("lft_busy_n", req, lft_busy_n, xlb);
        check("rgt_busy_n", req, rgt_busy_n, xrb);
        check("lft_wr_ok",  req, lft_wr_ok,  xlok);
        check("rgt_wr_ok",  req, rgt_wr_ok,  xrok);
    endtask

    initial begin
        // R1: reset held with a write collision on the ports.
        repeat (2) @(negedge clk);
        lft_en = 1; lft_wr = 1; lft_addr = A;
        rgt_en = 1; rgt_wr = 1; rgt_addr = A;
        @(posedge clk); @(negedge clk); #1;
        check_all(1, 1, 1, 0, 0);
        // R1 slave mode with busy imports low: still forced inactive.
        master_sel = 0; lft_busy_in_n = 0; rgt_busy_in_n = 0; #1;
        check_all(1, 1, 1, 0, 0);
        master_sel = 1; lft_busy_in_n = 1; rgt_busy_in_n = 1;
        // R5: released mid-collision with empty history, left wins.
        @(negedge clk); rst_n = 1; #1;
        check_all(5, 1, 0, 1, 0);
        @(negedge clk);
        lft_en = 0; lft_wr = 0; rgt_en = 0; rgt_wr = 0; #1;
        check_all(2, 1, 1, 0, 0);

        foreach (VECS[i]) begin
            @(negedge clk);
            master_sel    = VECS[i].m;
            lft_en        = VECS[i].le;
            lft_wr        = VECS[i].lw;
            lft_addr      = VECS[i].la;
            rgt_en        = VECS[i].re;
            rgt_wr        = VECS[i].rw;
            rgt_addr      = VECS[i].ra;
            lft_busy_in_n = VECS[i].lbi;
            rgt_busy_in_n = VECS[i].rbi;
            #1;
            check_all(int'(VECS[i].req), VECS[i].xlb, VECS[i].xrb,
                      VECS[i].xlok, VECS[i].xrok);
        end

        // R11: long collision with strobes toggling, never two losers.
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            master_sel = 1; lft_en = 1; rgt_en = 1;
            lft_addr = B; rgt_addr = B;
            lft_wr = k[0]; rgt_wr = k[1]; #1;
            check("one loser", 11, lft_busy_n | rgt_busy_n, 1'b1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule